// File: doc/BRIEF.md
# Dual-Domain Reset Release Sequencer

The sequencer takes one raw reset request and produces two reset outputs, one for each of two clock domains. The management domain gets an active-high reset, and the core domain gets an active-low reset. A rising request puts both outputs into reset at once, without waiting for either clock.

Each domain leaves reset on its own schedule. A domain is released only on an edge of its own clock, and only after the request and a reconfiguration-busy flag have both been low for a programmable number of that domain's clock cycles. While busy is high, neither domain can start or complete its hold count. Once a domain is out of reset, busy no longer affects it. Only a new request puts it back into reset.

Use the block wherever one reset source feeds logic in two clock domains that need opposite reset polarities. It is also suited to cases where a reconfiguration engine must be idle before the logic comes out of reset.

Top module: `dual_reset_sequencer`

## Requirements
- R1: While `rst_req` is high, `mgmt_rst` is 1 and `core_rst_n` is 0.
- R2: A rising `rst_req` drives `mgmt_rst` to 1 and `core_rst_n` to 0 in the same time step, with no clock edge needed.
- R3: `mgmt_rst` falls only at a rising edge of `mgmt_clk`, and `core_rst_n` rises only at a rising edge of `core_clk`.
- R4: Let HOLD_CYCLES be H, with the default of two synchronizer stages. A domain releases at the first own-clock edge E that meets two conditions. First, `rst_req` was low at every own edge from E-H-2 through E. Second, `reconfig_busy` was low at every own edge from E-H-2 through E-3. If both inputs stay low, release comes on the (H+3)-th own edge after the later of the two falls.
- R5: While `reconfig_busy` is high, neither output releases. A busy pulse that lands during a hold count restarts the full count.
- R6: A new request during a hold count restarts the full count once the request is removed.
- R7: After a domain is released, it stays released while `rst_req` is low, whatever `reconfig_busy` does.
- R8: Each domain releases independently. The faster domain does not wait for the slower one.
- R9: After power-up with the request asserted, both outputs read as asserted, with no release pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mgmt_clk | input | 1 | Management-domain clock |
| core_clk | input | 1 | Core-domain clock |
| rst_req | input | 1 | Raw reset request, active high, asynchronous |
| reconfig_busy | input | 1 | Reconfiguration-busy flag, asynchronous; blocks release while high |
| mgmt_rst | output | 1 | Management-domain reset, active high |
| core_rst_n | output | 1 | Core-domain reset, active low |

## Verification
Two events can fall on the same own-clock edge: a domain's hold count completing, and a busy rise or new request arriving. Random stimulus toggles the request and busy at random cycle gaps, so both often change within a few edges of an expected release. Directed cases place a busy pulse and a repeated request partway through a count. An edge-accurate reference model built from R4 predicts each output in every cycle. Separate monitors confirm two further points: every release coincides with the domain's own clock edge, and every assertion is immediate.

// File: rtl/dual_reset_sequencer.sv
`timescale 1ns/1ps
module dual_reset_sequencer #(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic mgmt_clk,
  input  logic core_clk,
  input  logic rst_req,
  input  logic reconfig_busy,
  output logic mgmt_rst,
  output logic core_rst_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYCLES);

  logic [1:0] dom_clk;
  logic [1:0] released;

  assign dom_clk = {core_clk, mgmt_clk};

  for (genvar d = 0; d < 2; d++) begin : g_dom
    logic [SYNC_STAGES-1:0] req_pipe;
    logic [SYNC_STAGES-1:0] busy_pipe;
    logic [CW-1:0]          hold_cnt;
    logic                   rel_q;
    logic                   armed;

    assign armed       = !req_pipe[SYNC_STAGES-1] && !busy_pipe[SYNC_STAGES-1];
    assign released[d] = rel_q;

    always_ff @(posedge dom_clk[d] or posedge rst_req) begin
      if (rst_req) begin
        req_pipe  <= '1;
        busy_pipe <= '1;
        hold_cnt  <= '0;
        rel_q     <= 1'b0;
      end else begin
        req_pipe  <= {req_pipe[SYNC_STAGES-2:0], 1'b0};
        busy_pipe <= {busy_pipe[SYNC_STAGES-2:0], reconfig_busy};
        if (!armed)
          hold_cnt <= '0;
        else if (hold_cnt != HOLD_END)
          hold_cnt <= hold_cnt + 1'b1;
        if (hold_cnt == HOLD_END)
          rel_q <= 1'b1;
      end
    end
  end

  assign mgmt_rst   = ~released[0];
  assign core_rst_n =  released[1];
endmodule

// File: rtl/reset_seq_chk.sv
`timescale 1ns/1ps
module reset_seq_chk #(
  parameter int HOLD_CYCLES = 16
) (
  input logic mgmt_clk,
  input logic core_clk,
  input logic rst_req,
  input logic reconfig_busy,
  input logic mgmt_rst,
  input logic core_rst_n
);
  logic [1:0] m_low, c_low;
  int unsigned m_quiet, c_quiet;

  always_ff @(posedge mgmt_clk or posedge rst_req) begin
    if (rst_req) begin
      m_low <= '0;
      m_quiet <= 0;
    end else begin
      m_low <= {m_low[0], ~reconfig_busy};
      m_quiet <= m_low[1] ? ((m_quiet >= HOLD_CYCLES) ? HOLD_CYCLES : m_quiet + 1) : 0;
    end
  end

  always_ff @(posedge core_clk or posedge rst_req) begin
    if (rst_req) begin
      c_low <= '0;
      c_quiet <= 0;
    end else begin
      c_low <= {c_low[0], ~reconfig_busy};
      c_quiet <= c_low[1] ? ((c_quiet >= HOLD_CYCLES) ? HOLD_CYCLES : c_quiet + 1) : 0;
    end
  end

  always @(posedge mgmt_clk) begin
    // R1
    if (rst_req) both_asserted_chk: assert (mgmt_rst && !core_rst_n);
  end

  // R4
  mgmt_gate_chk: assert property (@(posedge mgmt_clk) disable iff (rst_req)
    $fell(mgmt_rst) |-> $past(m_quiet) >= HOLD_CYCLES);

  // R4
  core_gate_chk: assert property (@(posedge core_clk) disable iff (rst_req)
    $rose(core_rst_n) |-> $past(c_quiet) >= HOLD_CYCLES);

  // R7
  mgmt_stay_chk: assert property (@(posedge mgmt_clk) disable iff (rst_req)
    !mgmt_rst |=> !mgmt_rst);

  // R7
  core_stay_chk: assert property (@(posedge core_clk) disable iff (rst_req)
    core_rst_n |=> core_rst_n);
endmodule

bind dual_reset_sequencer reset_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .mgmt_clk(mgmt_clk), .core_clk(core_clk), .rst_req(rst_req),
  .reconfig_busy(reconfig_busy), .mgmt_rst(mgmt_rst), .core_rst_n(core_rst_n)
);

// File: tb/sim_dual_reset_sequencer.sv
`timescale 1ns/1ps
module sim_dual_reset_sequencer;
  localparam int HOLD = 16;

  logic mgmt_clk = 1'b0;
  logic core_clk = 1'b0;
  logic rst_req = 1'b0;
  logic reconfig_busy = 1'b0;
  logic mgmt_rst, core_rst_n;

  int vectors = 0;
  int fails = 0;
  string phase = "R9";
  bit finished = 1'b0;

  always #2.5 mgmt_clk = ~mgmt_clk;
  always #3.75 core_clk = ~core_clk;

  dual_reset_sequencer #(.HOLD_CYCLES(HOLD)) u0 (
    .mgmt_clk(mgmt_clk), .core_clk(core_clk), .rst_req(rst_req),
    .reconfig_busy(reconfig_busy), .mgmt_rst(mgmt_rst), .core_rst_n(core_rst_n)
  );

  // reference model per domain, built from R4
  bit m_d1, m_d2, m_rel, c_d1, c_d2, c_rel;
  int m_run, c_run;
  realtime m_edge, c_edge;

  function automatic int bump(input int run);
    return (run >= HOLD) ? HOLD : run + 1;
  endfunction

  always @(posedge mgmt_clk) begin
    m_edge = $realtime;
    if (rst_req) begin
      m_d1 = 0; m_d2 = 0; m_run = 0; m_rel = 0;
    end else begin
      m_rel = m_rel || (m_run == HOLD);
      m_run = m_d2 ? bump(m_run) : 0;
      m_d2 = m_d1;
      m_d1 = !reconfig_busy;
    end
  end

  always @(posedge core_clk) begin
    c_edge = $realtime;
    if (rst_req) begin
      c_d1 = 0; c_d2 = 0; c_run = 0; c_rel = 0;
    end else begin
      c_rel = c_rel || (c_run == HOLD);
      c_run = c_d2 ? bump(c_run) : 0;
      c_d2 = c_d1;
      c_d1 = !reconfig_busy;
    end
  end

  // per-cycle comparison (R1, R4..R9 depending on phase)
  always @(posedge mgmt_clk) begin
    #2;
    if (!finished) begin
      logic exp_m;
      exp_m = !(m_rel && !rst_req);
      vectors++;
      if (mgmt_rst !== exp_m) begin
        fails++;
        $display("FAIL %s mgmt_rst=%b expected %b at %0t", phase, mgmt_rst, exp_m, $time);
      end
    end
  end

  always @(posedge core_clk) begin
    #2;
    if (!finished) begin
      logic exp_c;
      exp_c = c_rel && !rst_req;
      vectors++;
      if (core_rst_n !== exp_c) begin
        fails++;
        $display("FAIL %s core_rst_n=%b expected %b at %0t", phase, core_rst_n, exp_c, $time);
      end
    end
  end

  // R3: releases land on the own clock edge
  always @(negedge mgmt_rst) begin
    if (!rst_req && !finished) begin
      vectors++;
      if ($realtime != m_edge) begin
        fails++;
        $display("FAIL R3 mgmt release at %0t expected at edge %0t", $realtime, m_edge);
      end
    end
  end

  always @(posedge core_rst_n) begin
    if (!rst_req && !finished) begin
      vectors++;
      if ($realtime != c_edge) begin
        fails++;
        $display("FAIL R3 core release at %0t expected at edge %0t", $realtime, c_edge);
      end
    end
  end

  task automatic chk(input string tag, input logic exp_m, input logic exp_c);
    vectors++;
    if (mgmt_rst !== exp_m || core_rst_n !== exp_c) begin
      fails++;
      $display("FAIL %s outputs %b/%b expected %b/%b at %0t",
               tag, mgmt_rst, core_rst_n, exp_m, exp_c, $time);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(posedge mgmt_clk);
    #1;
  endtask

  // R2: assertion is immediate for both outputs
  task automatic hit_req();
    rst_req = 1'b1;
    #0.1;
    chk("R2", 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_req = 1'b1;
    #0.5;
    chk("R9", 1'b1, 1'b0);
    go(20);
    chk("R1", 1'b1, 1'b0);

    phase = "R4";
    rst_req = 1'b0;
    go(HOLD + 5);
    chk("R8", 1'b0, 1'b0);
    go(20);
    chk("R4", 1'b0, 1'b1);

    phase = "R7";
    reconfig_busy = 1'b1;
    go(10);
    chk("R7", 1'b0, 1'b1);
    reconfig_busy = 1'b0;
    go(3);

    phase = "R5";
    hit_req();
    reconfig_busy = 1'b1;
    go(2);
    rst_req = 1'b0;
    go(40);
    chk("R5", 1'b1, 1'b0);
    reconfig_busy = 1'b0;
    go(10);
    reconfig_busy = 1'b1;
    go(5);
    reconfig_busy = 1'b0;
    go(HOLD + 2);
    chk("R5", 1'b1, 1'b0);
    go(30);
    chk("R5", 1'b0, 1'b1);

    phase = "R6";
    hit_req();
    go(3);
    rst_req = 1'b0;
    go(10);
    hit_req();
    go(2);
    rst_req = 1'b0;
    go(HOLD);
    chk("R6", 1'b1, 1'b0);
    go(30);
    chk("R6", 1'b0, 1'b1);

    phase = "R4";
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 1) == 0) begin
        if (rst_req) rst_req = 1'b0;
        else hit_req();
      end else begin
        reconfig_busy = ~reconfig_busy;
      end
      go($urandom_range(1, 30));
    end
    rst_req = 1'b0;
    reconfig_busy = 1'b0;
    go(40);
    chk("R4", 1'b0, 1'b1);
    finish_run();
  end
endmodule